// File: doc/BRIEF.md
# CBC Block Cipher Command Sequencer

This block drives a 128-bit block-cipher core through multi-block cipher block chaining (CBC) jobs. Software loads a 128-bit key and a 128-bit initial vector through two write-only 32-bit word ports. It then starts a job by writing a control word, which selects whether the cipher is used, the direction, where the chaining value comes from, and how many blocks to process. The sequencer pulls 128-bit blocks from a valid/ready source stream and applies the CBC XOR. It exchanges each block with the cipher core over a request/response handshake and pushes the results onto a valid/ready sink stream.

The chaining value is kept after a job ends, so one long message can be split across several jobs. With the enable bit clear, the block becomes a plain block-copy engine: the core sits idle and the chaining value is left alone. A busy level covers the whole job, and a one-cycle done pulse marks its end.

Top module: `cbc_chain_engine`

## Requirements
- R1: The key is assembled from four writes on the key word port, most significant word first. After the fourth write, `core_key_o` shows the whole new key.
- R2: The IV is assembled in the same way on its own port. After one to three writes of a sequence the stored IV is unchanged. The fourth write replaces all 128 bits at once.
- R3: Control word fields are: bit 0 enable, bit 1 decrypt, bit 2 carry chain, and bits [8 +: CNT_W] the block count minus one. A write is accepted only while idle. `busy_o` is high from the cycle after an accepted write until the last output block is taken. Writes made while busy have no effect.
- R4: A count field of N processes exactly N+1 blocks, so 0 processes one block.
- R5: Encryption (bit 1 clear) sends plaintext XOR chain to the core with `core_req_dec_o` low. The core result is output and becomes the new chain.
- R6: Decryption (bit 1 set) sends the ciphertext block to the core with `core_req_dec_o` high. It outputs core result XOR chain, and the input ciphertext becomes the new chain.
- R7: With the carry bit clear, the first block chains from the loaded IV. With it set, chaining continues from the last block of the previous enabled job.
- R8: With the enable bit clear, every block is output unchanged, no core request is raised, and the chaining value is not modified.
- R9: `done_o` is a one-cycle pulse in the cycle after the last sink handshake, and `busy_o` is low in that cycle.
- R10: `snk_valid_o` and `core_req_valid_o` stay high with stable data until their handshakes complete. When idle, no stream or core valid/ready output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_wr_i | input | 1 | Key word write strobe |
| key_wdata_i | input | 32 | Key word |
| iv_wr_i | input | 1 | IV word write strobe |
| iv_wdata_i | input | 32 | IV word |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 32 | Control word |
| src_valid_i | input | 1 | Source block valid |
| src_data_i | input | 128 | Source block |
| src_ready_o | output | 1 | Source block accepted |
| core_req_valid_o | output | 1 | Cipher request valid |
| core_req_ready_i | input | 1 | Cipher core takes request |
| core_req_data_o | output | 128 | Block sent to the core |
| core_req_dec_o | output | 1 | Core direction, 1 = decrypt |
| core_key_o | output | 128 | Key for the core |
| core_rsp_valid_i | input | 1 | Core result valid |
| core_rsp_ready_o | output | 1 | Sequencer waits for a result |
| core_rsp_data_i | input | 128 | Core result block |
| snk_valid_o | output | 1 | Output block valid |
| snk_ready_i | input | 1 | Sink takes block |
| snk_data_o | output | 128 | Output block |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | One-cycle end-of-job pulse |

## Verification
The assertions assume that the cipher core returns exactly one response per accepted request, and only after that request. They also assume the sink may stall for any number of cycles. The stub core in the bench follows this rule with a random latency of zero to two cycles. It computes an invertible keyed function that the bench mirrors for its expected values. The source, the core and the sink all toggle their valid or ready signals from a seeded random draw. Key, IV and control writes are made only between handshake edges, and the one control write made during a job is a deliberate test of R3.

// File: rtl/cbc_chain_pkg.sv
package cbc_chain_pkg;
  localparam int unsigned BLK_W     = 128;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned DEC_BIT   = 1;
  localparam int unsigned CARRY_BIT = 2;
  localparam int unsigned CNT_LSB   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CORE,
    ST_WAIT,
    ST_EMIT
  } seq_state_e;

  typedef struct packed {
    logic en;
    logic dec;
    logic carry;
  } cmd_mode_t;
endpackage

// File: rtl/cbc_word_loader.sv
module cbc_word_loader #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned WORDS  = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_i,
  input  logic [WORD_W-1:0]        wdata_i,
  output logic [WORD_W*WORDS-1:0]  value_o
);
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int unsigned STG_W = WORD_W * (WORDS - 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

  logic [IDX_W-1:0]        idx_q;
  logic [STG_W-1:0]        stage_q;
  logic [WORD_W*WORDS-1:0] value_q;

  // earlier words sit higher; the final word completes the value in one edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      stage_q <= '0;
      value_q <= '0;
    end else if (wr_i) begin
      if (idx_q == LAST_IDX) begin
        value_q <= {stage_q, wdata_i};
        idx_q   <= '0;
      end else begin
        stage_q <= (stage_q << WORD_W) | STG_W'(wdata_i);
        idx_q   <= idx_q + IDX_W'(1);
      end
    end
  end

  assign value_o = value_q;
endmodule

// File: rtl/cbc_seq_ctrl.sv
module cbc_seq_ctrl
  import cbc_chain_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              src_valid_i,
  input  logic              core_req_ready_i,
  input  logic              core_rsp_valid_i,
  input  logic              snk_ready_i,
  output cmd_mode_t         mode_o,
  output logic              load_iv_o,
  output logic              fetch_o,
  output logic              rsp_fire_o,
  output logic              src_ready_o,
  output logic              core_req_valid_o,
  output logic              core_rsp_ready_o,
  output logic              snk_valid_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q;
  cmd_mode_t        mode_q;
  logic             done_q;
  logic             start, emit_fire, last_blk;
  cmd_mode_t        wr_mode;
  logic             unused_ctrl_bits;

  assign wr_mode.en    = ctrl_wdata_i[EN_BIT];
  assign wr_mode.dec   = ctrl_wdata_i[DEC_BIT];
  assign wr_mode.carry = ctrl_wdata_i[CARRY_BIT];
  assign unused_ctrl_bits = ^{ctrl_wdata_i[CTRL_W-1:CNT_LSB+CNT_W], ctrl_wdata_i[CNT_LSB-1:3]};

  assign start     = ctrl_wr_i && (state_q == ST_IDLE);
  assign emit_fire = (state_q == ST_EMIT) && snk_ready_i;
  assign last_blk  = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (ctrl_wr_i) state_d = ST_FETCH;
      ST_FETCH: if (src_valid_i) state_d = mode_q.en ? ST_CORE : ST_EMIT;
      ST_CORE:  if (core_req_ready_i) state_d = ST_WAIT;
      ST_WAIT:  if (core_rsp_valid_i) state_d = ST_EMIT;
      ST_EMIT:  if (snk_ready_i) state_d = last_blk ? ST_IDLE : ST_FETCH;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      mode_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= emit_fire && last_blk;
      if (start) begin
        mode_q <= wr_mode;
        cnt_q  <= ctrl_wdata_i[CNT_LSB +: CNT_W];
      end else if (emit_fire && !last_blk) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign mode_o           = mode_q;
  assign load_iv_o        = start && wr_mode.en && !wr_mode.carry;
  assign src_ready_o      = (state_q == ST_FETCH);
  assign fetch_o          = src_ready_o && src_valid_i;
  assign core_req_valid_o = (state_q == ST_CORE);
  assign core_rsp_ready_o = (state_q == ST_WAIT);
  assign rsp_fire_o       = core_rsp_ready_o && core_rsp_valid_i;
  assign snk_valid_o      = (state_q == ST_EMIT);
  assign busy_o           = (state_q != ST_IDLE);
  assign done_o           = done_q;
endmodule

// File: rtl/cbc_chain_datapath.sv
module cbc_chain_datapath
  import cbc_chain_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_mode_t        mode_i,
  input  logic             load_iv_i,
  input  logic             fetch_i,
  input  logic             rsp_fire_i,
  input  logic [BLK_W-1:0] iv_i,
  input  logic [BLK_W-1:0] src_data_i,
  input  logic [BLK_W-1:0] core_rsp_data_i,
  output logic [BLK_W-1:0] core_req_data_o,
  output logic [BLK_W-1:0] snk_data_o
);
  logic [BLK_W-1:0] blk_q, res_q, chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blk_q   <= '0;
      res_q   <= '0;
      chain_q <= '0;
    end else begin
      if (load_iv_i) chain_q <= iv_i;
      if (fetch_i) begin
        blk_q <= src_data_i;
        if (!mode_i.en) res_q <= src_data_i;  // copy path
      end
      if (rsp_fire_i) begin
        if (mode_i.dec) begin
          res_q   <= core_rsp_data_i ^ chain_q;
          chain_q <= blk_q;
        end else begin
          res_q   <= core_rsp_data_i;
          chain_q <= core_rsp_data_i;
        end
      end
    end
  end

  assign core_req_data_o = mode_i.dec ? blk_q : (blk_q ^ chain_q);
  assign snk_data_o      = res_q;
endmodule

// File: rtl/cbc_chain_engine.sv
module cbc_chain_engine
  import cbc_chain_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              key_wr_i,
  input  logic [WORD_W-1:0] key_wdata_i,
  input  logic              iv_wr_i,
  input  logic [WORD_W-1:0] iv_wdata_i,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              src_valid_i,
  input  logic [BLK_W-1:0]  src_data_i,
  output logic              src_ready_o,
  output logic              core_req_valid_o,
  input  logic              core_req_ready_i,
  output logic [BLK_W-1:0]  core_req_data_o,
  output logic              core_req_dec_o,
  output logic [BLK_W-1:0]  core_key_o,
  input  logic              core_rsp_valid_i,
  output logic              core_rsp_ready_o,
  input  logic [BLK_W-1:0]  core_rsp_data_i,
  output logic              snk_valid_o,
  input  logic              snk_ready_i,
  output logic [BLK_W-1:0]  snk_data_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int unsigned LOAD_WORDS = BLK_W / WORD_W;

  logic [BLK_W-1:0] key_val, iv_val;
  cmd_mode_t        mode;
  logic             load_iv, fetch, rsp_fire;

  cbc_word_loader #(.WORD_W(WORD_W), .WORDS(LOAD_WORDS)) u_key_ld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (key_wr_i),
    .wdata_i (key_wdata_i),
    .value_o (key_val)
  );

  cbc_word_loader #(.WORD_W(WORD_W), .WORDS(LOAD_WORDS)) u_iv_ld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (iv_wr_i),
    .wdata_i (iv_wdata_i),
    .value_o (iv_val)
  );

  cbc_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .ctrl_wr_i        (ctrl_wr_i),
    .ctrl_wdata_i     (ctrl_wdata_i),
    .src_valid_i      (src_valid_i),
    .core_req_ready_i (core_req_ready_i),
    .core_rsp_valid_i (core_rsp_valid_i),
    .snk_ready_i      (snk_ready_i),
    .mode_o           (mode),
    .load_iv_o        (load_iv),
    .fetch_o          (fetch),
    .rsp_fire_o       (rsp_fire),
    .src_ready_o      (src_ready_o),
    .core_req_valid_o (core_req_valid_o),
    .core_rsp_ready_o (core_rsp_ready_o),
    .snk_valid_o      (snk_valid_o),
    .busy_o           (busy_o),
    .done_o           (done_o)
  );

  cbc_chain_datapath u_dp (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .mode_i          (mode),
    .load_iv_i       (load_iv),
    .fetch_i         (fetch),
    .rsp_fire_i      (rsp_fire),
    .iv_i            (iv_val),
    .src_data_i      (src_data_i),
    .core_rsp_data_i (core_rsp_data_i),
    .core_req_data_o (core_req_data_o),
    .snk_data_o      (snk_data_o)
  );

  assign core_req_dec_o = mode.dec;
  assign core_key_o     = key_val;
endmodule

// File: rtl/cbc_chain_engine_chk.sv
module cbc_chain_engine_chk
  import cbc_chain_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy_o,
  input logic             done_o,
  input logic             src_ready_o,
  input logic             core_req_valid_o,
  input logic             core_req_ready_i,
  input logic [BLK_W-1:0] core_req_data_o,
  input logic             snk_valid_o,
  input logic             snk_ready_i,
  input logic [BLK_W-1:0] snk_data_o
);
  // R9
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R10
  snk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (snk_valid_o && !snk_ready_i) |=> (snk_valid_o && $stable(snk_data_o)));

  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (core_req_valid_o && !core_req_ready_i) |=> (core_req_valid_o && $stable(core_req_data_o)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!src_ready_o && !core_req_valid_o && !snk_valid_o));

  // R9
  done_after_emit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o));
endmodule

bind cbc_chain_engine cbc_chain_engine_chk u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .busy_o           (busy_o),
  .done_o           (done_o),
  .src_ready_o      (src_ready_o),
  .core_req_valid_o (core_req_valid_o),
  .core_req_ready_i (core_req_ready_i),
  .core_req_data_o  (core_req_data_o),
  .snk_valid_o      (snk_valid_o),
  .snk_ready_i      (snk_ready_i),
  .snk_data_o       (snk_data_o)
);

// File: tb/cbc_chain_engine_tb.sv
`timescale 1ns/1ps
module cbc_chain_engine_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_ni = 1'b0;
  logic         key_wr_i = 1'b0, iv_wr_i = 1'b0, ctrl_wr_i = 1'b0;
  logic [31:0]  key_wdata_i = '0, iv_wdata_i = '0, ctrl_wdata_i = '0;
  logic         src_valid_i = 1'b0;
  logic [127:0] src_data_i = '0;
  logic         src_ready_o;
  logic         core_req_valid_o, core_req_dec_o, core_rsp_ready_o;
  logic         core_req_ready_i = 1'b0, core_rsp_valid_i = 1'b0;
  logic [127:0] core_req_data_o, core_key_o;
  logic [127:0] core_rsp_data_i = '0;
  logic         snk_valid_o, busy_o, done_o;
  logic         snk_ready_i = 1'b0;
  logic [127:0] snk_data_o;

  cbc_chain_engine u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .key_wr_i(key_wr_i), .key_wdata_i(key_wdata_i),
    .iv_wr_i(iv_wr_i), .iv_wdata_i(iv_wdata_i),
    .ctrl_wr_i(ctrl_wr_i), .ctrl_wdata_i(ctrl_wdata_i),
    .src_valid_i(src_valid_i), .src_data_i(src_data_i), .src_ready_o(src_ready_o),
    .core_req_valid_o(core_req_valid_o), .core_req_ready_i(core_req_ready_i),
    .core_req_data_o(core_req_data_o), .core_req_dec_o(core_req_dec_o),
    .core_key_o(core_key_o),
    .core_rsp_valid_i(core_rsp_valid_i), .core_rsp_ready_o(core_rsp_ready_o),
    .core_rsp_data_i(core_rsp_data_i),
    .snk_valid_o(snk_valid_o), .snk_ready_i(snk_ready_i), .snk_data_o(snk_data_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  int core_fires = 0;
  logic [127:0] src_q[$];
  logic [127:0] got_q[$];
  logic [127:0] stim[0:31];
  logic [127:0] m_key, m_iv, m_chain;

  function automatic logic [127:0] enc_f(input logic [127:0] x, input logic [127:0] k);
    logic [127:0] t;
    t = x ^ k;
    return {t[114:0], t[127:115]};
  endfunction

  function automatic logic [127:0] dec_f(input logic [127:0] y, input logic [127:0] k);
    return {y[12:0], y[127:13]} ^ k;
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [31:0] ctrl_w(input bit en, input bit dec, input bit carry, input int n);
    logic [31:0] w;
    w = '0;
    w[0] = en;
    w[1] = dec;
    w[2] = carry;
    w[15:8] = 8'(n - 1);
    return w;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // environment: source, stub core, sink
  initial begin : env
    bit src_f, req_f, rsp_f;
    bit pend;
    int wait_cyc;
    logic [127:0] pend_data;
    pend = 0;
    wait_cyc = 0;
    pend_data = '0;
    forever begin
      @(negedge clk);
      src_f = src_valid_i && src_ready_o;
      req_f = core_req_valid_o && core_req_ready_i;
      rsp_f = core_rsp_valid_i && core_rsp_ready_o;
      if (snk_valid_o && snk_ready_i) got_q.push_back(snk_data_o);
      if (req_f) begin
        core_fires++;
        pend_data = core_req_dec_o ? dec_f(core_req_data_o, core_key_o)
                                   : enc_f(core_req_data_o, core_key_o);
        pend = 1;
        wait_cyc = int'($urandom() % 3);
      end
      @(posedge clk);
      #1;
      if (src_f) void'(src_q.pop_front());
      src_valid_i = (src_q.size() > 0) && ($urandom() % 4 != 0);
      src_data_i  = (src_q.size() > 0) ? src_q[0] : '0;
      if (rsp_f) core_rsp_valid_i = 1'b0;
      if (pend) begin
        if (wait_cyc == 0) begin
          core_rsp_valid_i = 1'b1;
          core_rsp_data_i  = pend_data;
          pend = 0;
        end else begin
          wait_cyc--;
        end
      end
      core_req_ready_i = ($urandom() % 3 != 0);
      snk_ready_i      = ($urandom() % 4 != 0);
    end
  end

  task automatic wr_key(input logic [31:0] w);
    @(negedge clk); key_wr_i = 1'b1; key_wdata_i = w;
    @(negedge clk); key_wr_i = 1'b0;
  endtask

  task automatic wr_iv(input logic [31:0] w);
    @(negedge clk); iv_wr_i = 1'b1; iv_wdata_i = w;
    @(negedge clk); iv_wr_i = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [31:0] w);
    @(negedge clk); ctrl_wr_i = 1'b1; ctrl_wdata_i = w;
    @(negedge clk); ctrl_wr_i = 1'b0;
  endtask

  task automatic run_cmd(input string tag, input bit en, input bit dec, input bit carry,
                         input int n, input bit stray);
    logic [127:0] ch, e, exp_blk[0:31];
    int c0, t;
    ch = m_chain;
    if (en && !carry) ch = m_iv;
    for (int i = 0; i < n; i++) begin
      if (!en) e = stim[i];
      else if (!dec) begin
        e = enc_f(stim[i] ^ ch, m_key);
        ch = e;
      end else begin
        e = dec_f(stim[i], m_key) ^ ch;
        ch = stim[i];
      end
      exp_blk[i] = e;
    end
    got_q.delete();
    c0 = core_fires;
    @(negedge clk);
    for (int i = 0; i < n; i++) src_q.push_back(stim[i]);
    wr_ctrl(ctrl_w(en, dec, carry, n));
    chk({tag, " R3 busy after start"}, 128'(busy_o), 128'(1));
    if (stray) begin
      repeat (3) @(negedge clk);
      wr_ctrl(ctrl_w(1'b1, 1'b0, 1'b0, 1)); // R3: ignored while busy
    end
    t = 0;
    while (!done_o && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk({tag, " R9 done seen"}, 128'(done_o), 128'(1));
    chk({tag, " R9 busy low at done"}, 128'(busy_o), 128'(0));
    chk({tag, " R4 block count"}, 128'(got_q.size()), 128'(n));
    for (int i = 0; i < n; i++)
      chk($sformatf("%s blk%0d", tag, i), (i < got_q.size()) ? got_q[i] : 'x, exp_blk[i]);
    if (!en) chk({tag, " R8 no core request"}, 128'(core_fires - c0), 128'(0));
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, 128'(done_o), 128'(0));
    m_chain = ch;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] new_iv, pt[0:2], ct[0:2];
    void'($urandom(32'h5eed_c0de));
    m_chain = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset busy", 128'(busy_o), 128'(0));
    chk("R9 reset done", 128'(done_o), 128'(0));
    chk("R10 reset snk_valid", 128'(snk_valid_o), 128'(0));
    chk("R10 reset req_valid", 128'(core_req_valid_o), 128'(0));
    chk("R10 reset src_ready", 128'(src_ready_o), 128'(0));
    rst_ni = 1'b1;

    // R1 key order
    m_key = rnd128();
    for (int i = 3; i >= 0; i--) wr_key(m_key[i*32 +: 32]);
    @(negedge clk);
    chk("R1 key word order", core_key_o, m_key);
    m_iv = rnd128();
    for (int i = 3; i >= 0; i--) wr_iv(m_iv[i*32 +: 32]);

    // R4 single block, R5 encrypt from IV
    stim[0] = rnd128();
    run_cmd("R4 R5 enc one", 1, 0, 0, 1, 0);
    // R7 carry across commands
    for (int i = 0; i < 4; i++) stim[i] = rnd128();
    run_cmd("R7 enc carry", 1, 0, 1, 4, 0);
    // R8 bypass, then carry must see the pre-bypass chain
    for (int i = 0; i < 3; i++) stim[i] = rnd128();
    run_cmd("R8 bypass", 0, 1, 0, 3, 0);
    for (int i = 0; i < 2; i++) stim[i] = rnd128();
    run_cmd("R8 R7 carry after bypass", 1, 0, 1, 2, 0);

    // R2 partial IV load keeps old IV
    new_iv = rnd128();
    for (int i = 3; i >= 1; i--) wr_iv(new_iv[i*32 +: 32]);
    for (int i = 0; i < 2; i++) stim[i] = rnd128();
    run_cmd("R2 partial iv", 1, 0, 0, 2, 0);
    wr_iv(new_iv[31:0]);
    m_iv = new_iv;
    stim[0] = rnd128();
    run_cmd("R2 full iv", 1, 0, 0, 1, 0);

    // R6 round trip
    for (int i = 0; i < 3; i++) begin pt[i] = rnd128(); stim[i] = pt[i]; end
    run_cmd("R5 enc rt", 1, 0, 0, 3, 0);
    for (int i = 0; i < 3; i++) begin ct[i] = got_q[i]; stim[i] = ct[i]; end
    run_cmd("R6 dec rt", 1, 1, 0, 3, 0);
    for (int i = 0; i < 3; i++) chk("R6 roundtrip plaintext", got_q[i], pt[i]);

    // R3 control write during a job
    for (int i = 0; i < 5; i++) stim[i] = rnd128();
    run_cmd("R3 stray ctrl", 1, 0, 0, 5, 1);

    // R4 longest directed job
    for (int i = 0; i < 16; i++) stim[i] = rnd128();
    run_cmd("R4 R6 dec 16", 1, 1, 1, 16, 0);

    // random mix
    for (int k = 0; k < 20; k++) begin
      int n;
      bit en, dec, carry;
      n = 1 + int'($urandom() % 16);
      en = ($urandom() % 4 != 0);
      dec = $urandom() % 2;
      carry = $urandom() % 2;
      for (int i = 0; i < n; i++) stim[i] = rnd128();
      run_cmd($sformatf("R5 R6 R7 R8 rnd%0d", k), en, dec, carry, n, 0);
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule